// File: doc/BRIEF.md
# Critical-Word-First Burst Order Sequencer

This block produces the sequence of word offsets used to refill one cache line. The first offset is always the word that missed. A requester starts a burst by presenting the missed word offset and an order mode. After that, the block emits one offset per accepted beat on a valid/ready output. Two orders are supported, and the mode is chosen separately for each burst. Linear-wrap order runs upward to the end of the line and then continues from word 0. Interleaved order XORs the missed offset with the beat number.

The downstream consumer is a bus master or a burst-capable memory. It accepts beats at its own pace by driving the ready input. Each beat carries two flags. One marks the final beat of the line. The other marks the beat that carries the critical word, so the pipeline can restart early. Data movement, tags and memory timing are handled elsewhere.

Top module: `burst_order_seq`

## Requirements
- R1: After a synchronous active-low reset, `beat_valid` is 0 and `start_ready` is 1.
- R2: The first beat of every burst carries the missed offset presented with the accepted start, and `beat_critical` is 1 on that beat and only on that beat.
- R3: When `start_mode` is 0 (linear wrap), beat n carries offset (start + n) mod 4. For example, a miss on word 1 gives 1, 2, 3, 0.
- R4: When `start_mode` is 1 (interleaved), beat n carries offset start XOR n. For example, a miss on word 1 gives 1, 0, 3, 2.
- R5: The beat index advances only in a cycle where `beat_valid` and `beat_ready` are both 1. While `beat_ready` is 0, the offset and flags hold steady.
- R6: `beat_last` is 1 on the fourth beat (n = 3) and on no other beat. Each burst is exactly four accepted beats.
- R7: While a burst is in progress, `start_ready` is 0 and any `start_valid` is ignored. The sequence that is running does not change.
- R8: The mode and missed offset are captured when the start is accepted. Changing `start_mode` or `start_offset` later in the burst has no effect on it.
- R9: In the cycle after the last beat is accepted, `beat_valid` is 0 and `start_ready` is 1. A new burst can then be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_valid | input | 1 | Request to start a refill burst |
| start_ready | output | 1 | Sequencer idle, able to accept a start |
| start_offset | input | 2 | Word offset that missed |
| start_mode | input | 1 | 0 = linear wrap, 1 = interleaved |
| beat_valid | output | 1 | Offset on `beat_offset` is valid |
| beat_ready | input | 1 | Consumer accepts the current beat |
| beat_offset | output | 2 | Word offset for this beat |
| beat_last | output | 1 | This is the final beat of the line |
| beat_critical | output | 1 | This beat carries the missed word |

## Verification
The bench runs every missed offset in both modes under three stall patterns and compares each beat against the arithmetic formula.

- **Wrong wrap or XOR.** A design that mixed the two formulas, or dropped the wrap, would emit a wrong offset on beat 1, 2 or 3.
- **Stall handling.** While stalled, the bench toggles the start inputs and raises a fresh request. A design that re-captured them would switch order or offset mid-line. A design that stepped without a handshake would skip an offset.
- **Burst boundaries.** The bench checks that the last and critical flags appear only on their own beats. It also checks that the block reaches idle one cycle after the fourth accept, which catches off-by-one beat counts.

// File: rtl/burst_order_pkg.sv
// Package: shared types for the burst order sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package burst_order_pkg;

    // Sequencer control state
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Burst order selected per burst
    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_mode_e;

endpackage

// File: rtl/burst_seq_ctrl.sv
// Module: burst_seq_ctrl
// Does: idle/run state machine and beat counter for one line refill.
//       Accepts a start only while idle and steps the beat index on each
//       output handshake. Returns to idle after the final beat.
// Assumes: LINE_WORDS is a power of two, at least 2.
module burst_seq_ctrl
    import burst_order_pkg::*;
#(
    parameter int LINE_WORDS = 4,
    parameter int OFF_W      = $clog2(LINE_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_valid,
    output logic             start_ready,
    output logic             start_take,
    output logic             beat_valid,
    input  logic             beat_ready,
    output logic [OFF_W-1:0] beat_idx,
    output logic             beat_last,
    output logic             beat_first
);

    localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(LINE_WORDS - 1);

    seq_state_e       state_q;
    logic [OFF_W-1:0] idx_q;
    logic             beat_fire;

    // Decode handshakes and beat flags from the current state
    always_comb begin
        start_ready = (state_q == SEQ_IDLE);
        start_take  = start_ready && start_valid;
        beat_valid  = (state_q == SEQ_RUN);
        beat_fire   = beat_valid && beat_ready;
        beat_last   = beat_valid && (idx_q == LAST_IDX);
        beat_first  = beat_valid && (idx_q == '0);
        beat_idx    = idx_q;
    end

    // State and beat index update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_take) begin
                        state_q <= SEQ_RUN;
                        idx_q   <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (beat_fire) begin
                        if (idx_q == LAST_IDX) begin
                            state_q <= SEQ_IDLE;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // A stalled beat keeps its index
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> (beat_valid && idx_q == $past(idx_q)));

    // A non-final accepted beat is followed by another beat
    assert_not_last_continues_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && !beat_last) |=> beat_valid);

endmodule

// File: rtl/burst_req_latch.sv
// Module: burst_req_latch
// Does: captures the missed offset and order mode when a start is taken,
//       and holds them for the rest of the burst.
// Assumes: take is asserted only while the sequencer is idle.
module burst_req_latch
    import burst_order_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [OFF_W-1:0] in_offset,
    input  logic             in_mode,
    output logic [OFF_W-1:0] cap_offset,
    output order_mode_e      cap_mode
);

    // Capture the request on acceptance only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_offset <= '0;
            cap_mode   <= ORDER_LINEAR;
        end else if (take) begin
            cap_offset <= in_offset;
            cap_mode   <= order_mode_e'(in_mode);
        end
    end

endmodule

// File: rtl/burst_offset_gen.sv
// Module: burst_offset_gen
// Does: maps the captured start offset and the beat index to a word offset.
//       Linear wrap adds modulo the line size. Interleave uses XOR.
// Assumes: the line size is 2**OFF_W, so the add wraps naturally.
module burst_offset_gen
    import burst_order_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic [OFF_W-1:0] start_off,
    input  order_mode_e      mode,
    input  logic [OFF_W-1:0] idx,
    output logic [OFF_W-1:0] offset
);

    logic [OFF_W-1:0] lin_off;
    logic [OFF_W-1:0] xor_off;

    // Per-bit XOR term for interleaved order
    for (genvar b = 0; b < OFF_W; b++) begin : g_xor_bit
        assign xor_off[b] = start_off[b] ^ idx[b];
    end

    // Linear order: modular add, then select the order for this burst
    always_comb begin
        lin_off = start_off + idx;
        offset  = (mode == ORDER_XOR) ? xor_off : lin_off;
    end

endmodule

// File: rtl/burst_order_seq.sv
// Module: burst_order_seq (top)
// Does: emits the critical-word-first offsets of one line refill, in either
//       linear-wrap or interleaved order, one per accepted beat.
// Assumes: a four-word line by default. The consumer may stall at any beat.
module burst_order_seq
    import burst_order_pkg::*;
#(
    parameter int LINE_WORDS = 4,
    parameter int OFF_W      = $clog2(LINE_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_valid,
    output logic             start_ready,
    input  logic [OFF_W-1:0] start_offset,
    input  logic             start_mode,
    output logic             beat_valid,
    input  logic             beat_ready,
    output logic [OFF_W-1:0] beat_offset,
    output logic             beat_last,
    output logic             beat_critical
);

    logic             take;
    logic [OFF_W-1:0] idx;
    logic [OFF_W-1:0] cap_offset;
    order_mode_e      cap_mode;

    burst_seq_ctrl #(.LINE_WORDS(LINE_WORDS), .OFF_W(OFF_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_valid (start_valid),
        .start_ready (start_ready),
        .start_take  (take),
        .beat_valid  (beat_valid),
        .beat_ready  (beat_ready),
        .beat_idx    (idx),
        .beat_last   (beat_last),
        .beat_first  (beat_critical)
    );

    burst_req_latch #(.OFF_W(OFF_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .in_offset  (start_offset),
        .in_mode    (start_mode),
        .cap_offset (cap_offset),
        .cap_mode   (cap_mode)
    );

    burst_offset_gen #(.OFF_W(OFF_W)) u_gen (
        .start_off (cap_offset),
        .mode      (cap_mode),
        .idx       (idx),
        .offset    (beat_offset)
    );

    // The first beat after an accepted start carries the missed word
    assert_first_is_missed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_ready) |=> (beat_valid && beat_critical &&
                                          beat_offset == $past(start_offset)));

    // A stalled beat keeps its offset
    assert_offset_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> $stable(beat_offset));

    // Captured request stays fixed across the burst
    assert_capture_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && $past(beat_valid)) |-> ($stable(cap_offset) && $stable(cap_mode)));

    // Accepting the last beat returns the block to idle
    assert_last_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && beat_last) |=> (!beat_valid && start_ready));

endmodule

// File: tb/burst_order_seq_bench.sv
// Bench: sweeps every missed offset, both orders, and several stall
// patterns. Expected offsets are computed arithmetically.
module burst_order_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_valid = 1'b0;
    logic       start_ready;
    logic [1:0] start_offset = '0;
    logic       start_mode = 1'b0;
    logic       beat_valid;
    logic       beat_ready = 1'b0;
    logic [1:0] beat_offset;
    logic       beat_last;
    logic       beat_critical;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    burst_order_seq u_burst_order_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_valid   (start_valid),
        .start_ready   (start_ready),
        .start_offset  (start_offset),
        .start_mode    (start_mode),
        .beat_valid    (beat_valid),
        .beat_ready    (beat_ready),
        .beat_offset   (beat_offset),
        .beat_last     (beat_last),
        .beat_critical (beat_critical)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int expect_off(input int s, input int m, input int n);
        return (m != 0) ? (s ^ n) : ((s + n) % 4);
    endfunction

    // One burst: start s, mode m, stall pattern p
    task automatic run_burst(input int s, input int m, input int p);
        chk("R9 idle before start", int'(start_ready), 1);
        start_valid  = 1'b1;
        start_offset = 2'(s);
        start_mode   = m[0];
        beat_ready   = 1'b0;
        step();
        for (int n = 0; n < 4; n++) begin
            int stalls;
            stalls = (p == 0) ? 0 : (p == 1) ? 1 : ((n + s) % 3);
            for (int k = 0; k < stalls; k++) begin
                // Disturb the start inputs while busy (R7, R8)
                start_valid  = 1'b1;
                start_offset = 2'(s + 1 + k);
                start_mode   = ~m[0];
                beat_ready   = 1'b0;
                chk("R7 busy blocks start", int'(start_ready), 0);
                chk("R5 valid while stalled", int'(beat_valid), 1);
                chk(m != 0 ? "R4 stalled offset" : "R3 stalled offset",
                    int'(beat_offset), expect_off(s, m, n));
                step();
            end
            start_valid  = (n % 2 == 0);
            start_offset = 2'(s ^ 3);
            start_mode   = ~m[0];
            beat_ready   = 1'b1;
            chk("R5 valid on beat", int'(beat_valid), 1);
            chk(m != 0 ? "R4 offset" : "R3 offset", int'(beat_offset), expect_off(s, m, n));
            if (n == 0) chk("R2 first is missed", int'(beat_offset), s);
            chk("R8 order unaffected", int'(beat_offset), expect_off(s, m, n));
            chk("R2 critical flag", int'(beat_critical), int'(n == 0));
            chk("R6 last flag", int'(beat_last), int'(n == 3));
            chk("R7 not ready while busy", int'(start_ready), 0);
            step();
        end
        start_valid = 1'b0;
        beat_ready  = 1'b0;
        chk("R9 valid low after last", int'(beat_valid), 0);
        chk("R9 ready after last", int'(start_ready), 1);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        step();
        chk("R1 valid in reset", int'(beat_valid), 0);
        chk("R1 ready in reset", int'(start_ready), 1);
        rst_n = 1'b1;
        step();
        chk("R1 valid after reset", int'(beat_valid), 0);
        chk("R1 ready after reset", int'(start_ready), 1);
        // Ready with no burst must not produce beats
        beat_ready = 1'b1;
        step();
        chk("R5 no beat without start", int'(beat_valid), 0);
        beat_ready = 1'b0;
        for (int p = 0; p < 3; p++)
            for (int m = 0; m < 2; m++)
                for (int s = 0; s < 4; s++)
                    run_burst(s, m, p);
        // Back-to-back bursts with idle gap of zero extra cycles
        run_burst(1, 1, 0);
        run_burst(1, 0, 0);
        finish_run();
    end

endmodule